// File: doc/BRIEF.md
# Serial port status flag register

This block holds the eight-bit status byte of an asynchronous serial port. Five of its bits are sticky event flags: transmit buffer empty, receive buffer full, overrun, framing error and parity error. The transmit and receive engines raise these flags through single-cycle event inputs. The CPU reads the byte through a simple strobe bus. The low three bits are reserved and always read as 1.

Software can only lower a flag through a two-step handshake. It must first read the byte while that flag is 1, which arms the flag. It must then write 0 to that bit position. Writing 1 never raises a flag, and any write disarms every flag.

The block also decides whether a completed character may enter the receive data register. It pulses `rxLoad` only for a clean character that arrives while the receive buffer is empty. A character that finishes while the buffer is still full is reported as an overrun, and the buffer keeps its old contents.

Top module: `sr_status`

## Requirements
- R1: After `rstN` is low, or in the cycle after `standby` is high, the status byte reads 0x87 and every arm is dropped.
- R2: Bits 2..0 always read 1, and writes to them have no effect.
- R3: A write of 1 to any of bits 7..3 never sets that flag.
- R4: A write of 0 to a flag bit clears the flag only if an earlier read saw that flag at 1; without such a read the flag stays 1.
- R5: Every write drops all arms, so a second write of 0 with no read in between changes nothing.
- R6: Bit 7 (transmit empty) is set one cycle after `txLoad`, and it stays 1 for every cycle in which `txEnable` is 0.
- R7: A character that completes (`rxDone`) with no frame or parity error while bit 6 (receive full) is 0 sets bit 6 and pulses `rxLoad` in the same cycle.
- R8: A character that completes while bit 6 is 1 sets bit 5 (overrun). `rxLoad` stays 0 for it and bit 6 stays 1.
- R9: `rxDone` with `frameErr` sets bit 4, and `rxDone` with `parityErr` sets bit 3. Either error keeps `rxLoad` at 0 and leaves bit 6 unchanged.
- R10: When a set event and a valid software clear hit the same flag in the same cycle, the flag stays 1.
- R11: A read arms only the flags that are 1 at the time of the read; a flag that rises later is not cleared by the following write of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous return to the initial value |
| rdStb | input | 1 | CPU read strobe for the status byte |
| wrStb | input | 1 | CPU write strobe for the status byte |
| wrData | input | 8 | CPU write data |
| rdData | output | 8 | Current status byte |
| txEnable | input | 1 | Transmitter enable control |
| txLoad | input | 1 | Transmit data moved into the shifter |
| rxDone | input | 1 | A received character has completed |
| frameErr | input | 1 | Stop bit of the completed character was 0 |
| parityErr | input | 1 | Parity of the completed character mismatched |
| rxLoad | output | 1 | Permission to load the receive data register |

## Verification
The assertions check on every cycle the properties that need no history: the initial value after standby, the reserved bits, transmit empty being held while the transmitter is off or being loaded, writes never raising the overrun flag, and the gating of `rxLoad` by errors and by a full buffer. The read-then-write clear handshake depends on earlier reads that a port-level property cannot see. For that reason the arming, the disarming by every write, the arming of only flags already set, and the set-wins collisions are shown only by the bench scenarios. This includes a sweep over all 32 clear masks applied to a fully set register.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int REG_W   = 8;
  localparam int NFLAG   = 5;
  localparam int RSVD_W  = REG_W - NFLAG;
  // flag vector index: 4 tx empty, 3 rx full, 2 overrun, 1 framing, 0 parity
  localparam int F_TXE   = 4;
  localparam int F_RXF   = 3;
  localparam int F_OVR   = 2;
  localparam int F_FRM   = 1;
  localparam int F_PAR   = 0;
  localparam logic [NFLAG-1:0]  FLAG_INIT = 5'b10000;
  localparam logic [RSVD_W-1:0] RSVD_VAL  = '1;

  typedef struct packed {
    logic [NFLAG-1:0] setMask;
    logic [NFLAG-1:0] clrMask;
    logic             init;
  } flagCmd_t;
endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import sr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             standby,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic [NFLAG-1:0] wrFlags,
  input  logic [NFLAG-1:0] flags,
  input  logic             txEnable,
  input  logic             txLoad,
  input  logic             rxDone,
  input  logic             frameErr,
  input  logic             parityErr,
  output flagCmd_t         cmd,
  output logic             rxLoad
);
  logic [NFLAG-1:0] arm;
  logic [NFLAG-1:0] setVec;
  logic             rxClean;

  // arms: captured by a read of set flags, dropped by any write or init
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              arm <= '0;
    else if (standby)       arm <= '0;
    else if (wrStb)         arm <= '0;
    else if (rdStb)         arm <= arm | flags;
  end

  assign rxClean = rxDone && !frameErr && !parityErr;

  always_comb begin
    setVec        = '0;
    setVec[F_TXE] = txLoad || !txEnable;
    setVec[F_RXF] = rxClean && !flags[F_RXF];
    setVec[F_OVR] = rxDone && flags[F_RXF];
    setVec[F_FRM] = rxDone && frameErr;
    setVec[F_PAR] = rxDone && parityErr;
  end

  always_comb begin
    cmd.init    = standby;
    cmd.setMask = setVec;
    cmd.clrMask = wrStb ? (arm & ~wrFlags) : '0;
  end

  assign rxLoad = setVec[F_RXF];
endmodule

// File: rtl/sr_data.sv
module sr_data
  import sr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  flagCmd_t         cmd,
  output logic [NFLAG-1:0] flags,
  output logic [REG_W-1:0] status
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 flags[i] <= FLAG_INIT[i];
      else if (cmd.init)         flags[i] <= FLAG_INIT[i];
      else if (cmd.setMask[i])   flags[i] <= 1'b1;
      else if (cmd.clrMask[i])   flags[i] <= 1'b0;
    end
  end

  assign status = {flags, RSVD_VAL};
endmodule

// File: rtl/sr_status.sv
module sr_status
  import sr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             standby,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             txEnable,
  input  logic             txLoad,
  input  logic             rxDone,
  input  logic             frameErr,
  input  logic             parityErr,
  output logic             rxLoad
);
  flagCmd_t         cmd;
  logic [NFLAG-1:0] flags;
  logic [RSVD_W-1:0] unusedLow;

  assign unusedLow = wrData[RSVD_W-1:0];

  sr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .standby(standby),
    .rdStb(rdStb), .wrStb(wrStb), .wrFlags(wrData[REG_W-1:RSVD_W]),
    .flags(flags), .txEnable(txEnable), .txLoad(txLoad),
    .rxDone(rxDone), .frameErr(frameErr), .parityErr(parityErr),
    .cmd(cmd), .rxLoad(rxLoad)
  );

  sr_data u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .flags(flags), .status(rdData)
  );
endmodule

// File: rtl/sr_status_chk.sv
module sr_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       standby,
  input logic       wrStb,
  input logic [7:0] rdData,
  input logic       txEnable,
  input logic       txLoad,
  input logic       rxDone,
  input logic       frameErr,
  input logic       parityErr,
  input logic       rxLoad
);
  p_init_value_r1: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> rdData == 8'h87);

  p_reserved_ones_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[2:0] == 3'b111);

  p_write_no_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !rdData[5] && !rxDone && !standby) |=> !rdData[5]);

  p_tx_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> rdData[7]);

  p_tx_load_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> rdData[7]);

  p_clean_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !frameErr && !parityErr && !rdData[6]) |-> rxLoad);

  p_overrun_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rdData[6]) |-> !rxLoad);

  p_overrun_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rdData[6] && !standby) |=> (rdData[5] && rdData[6]));

  p_error_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && (frameErr || parityErr)) |-> !rxLoad);
endmodule

bind sr_status sr_status_chk u_chk (
  .clk(clk), .rstN(rstN), .standby(standby), .wrStb(wrStb),
  .rdData(rdData), .txEnable(txEnable), .txLoad(txLoad),
  .rxDone(rxDone), .frameErr(frameErr), .parityErr(parityErr),
  .rxLoad(rxLoad)
);

// File: tb/sim_sr_status.sv
module sim_sr_status;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       standby = 1'b0;
  logic       rdStb = 1'b0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       txEnable = 1'b1;
  logic       txLoad = 1'b0;
  logic       rxDone = 1'b0;
  logic       frameErr = 1'b0;
  logic       parityErr = 1'b0;
  logic       rxLoad;
  logic       lastLoad;
  int         checks = 0;
  int         failures = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  sr_status u0 (
    .clk(clk), .rstN(rstN), .standby(standby), .rdStb(rdStb),
    .wrStb(wrStb), .wrData(wrData), .rdData(rdData),
    .txEnable(txEnable), .txLoad(txLoad), .rxDone(rxDone),
    .frameErr(frameErr), .parityErr(parityErr), .rxLoad(rxLoad)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd();
    rdStb = 1'b1; tick(); rdStb = 1'b0;
  endtask

  task automatic wr(logic [7:0] v);
    wrStb = 1'b1; wrData = v; tick(); wrStb = 1'b0;
  endtask

  task automatic rx(logic fe, logic pe);
    rxDone = 1'b1; frameErr = fe; parityErr = pe;
    #1 lastLoad = rxLoad;
    tick();
    rxDone = 1'b0; frameErr = 1'b0; parityErr = 1'b0;
  endtask

  task automatic sby();
    standby = 1'b1; tick(); standby = 1'b0;
  endtask

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    chk("R1 reset value", rdData, 8'h87);

    wr(8'hFF);
    chk("R3 write ones", rdData, 8'h87);
    wr(8'h00);
    chk("R4 unarmed clear", rdData, 8'h87);
    chk("R2 reserved bits", {5'b0, rdData[2:0]}, 8'h07);

    rx(1'b0, 1'b0);
    chk("R7 rxLoad pulse", {7'b0, lastLoad}, 8'h01);
    chk("R7 rx full set", rdData, 8'hC7);
    rx(1'b0, 1'b0);
    chk("R8 no load on overrun", {7'b0, lastLoad}, 8'h00);
    chk("R8 overrun set", rdData, 8'hE7);
    rx(1'b1, 1'b0);
    chk("R9 frame no load", {7'b0, lastLoad}, 8'h00);
    chk("R9 frame flag", rdData, 8'hF7);
    rx(1'b0, 1'b1);
    chk("R9 parity flag", rdData, 8'hFF);

    sby();
    rx(1'b1, 1'b0);
    chk("R9 frame error keeps rx full clear", rdData, 8'h97);
    chk("R9 frame error no load", {7'b0, lastLoad}, 8'h00);
    sby();
    rx(1'b0, 1'b0); rx(1'b1, 1'b1);

    wr(8'h00);
    chk("R4 no read no clear", rdData, 8'hFF);
    rd();
    wr(8'hFF);
    wr(8'h00);
    chk("R5 write drops arms", rdData, 8'hFF);

    for (int p = 0; p < 32; p++) begin
      sby();
      rx(1'b0, 1'b0);
      rx(1'b1, 1'b1);
      chk("R7 R8 R9 all flags set", rdData, 8'hFF);
      rd();
      wr({p[4:0], 3'b000});
      chk("R4 sweep clear mask", rdData, {p[4:0], 3'b111});
      wr(8'h00);
      chk("R5 sweep rewrite", rdData, {p[4:0], 3'b111});
    end

    sby();
    chk("R1 standby value", rdData, 8'h87);
    rd();
    rx(1'b0, 1'b0);
    wr(8'h00);
    chk("R11 late flag not armed", rdData, 8'h47);

    txLoad = 1'b1; tick(); txLoad = 1'b0;
    chk("R6 tx load sets", rdData, 8'hC7);
    rd();
    wr(8'h78);
    chk("R4 clear tx empty only", rdData, 8'h47);
    txEnable = 1'b0; tick();
    chk("R6 disabled sets", rdData, 8'hC7);
    rd();
    wr(8'h40);
    chk("R6 disabled holds", rdData, 8'hC7);
    txEnable = 1'b1;

    rd();
    txLoad = 1'b1; wrStb = 1'b1; wrData = 8'h00; tick();
    txLoad = 1'b0; wrStb = 1'b0;
    chk("R10 tx set beats clear", rdData, 8'h87);

    rx(1'b1, 1'b0);
    chk("R9 frame only", rdData, 8'h97);
    rd();
    rxDone = 1'b1; frameErr = 1'b1; wrStb = 1'b1; wrData = 8'h00; tick();
    rxDone = 1'b0; frameErr = 1'b0; wrStb = 1'b0;
    chk("R10 frame set beats clear", rdData, 8'h17);

    sby();
    chk("R1 standby again", rdData, 8'h87);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule